// File: doc/BRIEF.md
# Variable-Coefficient Allpass Delay Stage

This block is one first-order allpass section of the kind used in phasers and reverb diffusers. It keeps a line of past samples in on-chip storage. For every accepted input sample it reads the oldest stored value (the tail) and stores a new value made from the input and the scaled tail. It then produces an output from the tail and the negated, scaled stored value. With coefficient K, tail d and input x, the stored value is w = x + K·d and the output is y = d − K·w. Only the tail is scaled before the input is added. Scaling the sum (x + d) is a different filter, and this block never forms it.

The coefficient comes from one of two variants, chosen by a parameter. In one it is a constant, 0.37 by default. In the other it is sampled from a run-time input together with each sample, so a modulator can sweep it. Samples and coefficient are signed 24-bit Q1.23 values. Every product and every sum is clamped to full scale instead of wrapping. Each result appears a fixed two clock cycles after its input, and inputs may arrive on consecutive cycles.

Top module: `apf_stage`

## Requirements
- R1: For each accepted sample the value stored into the line is w = sat(x + sat(K·d)), where a product of two Q1.23 values is taken as floor(a·b / 2^23).
- R2: The output for each accepted sample is y = sat(d − sat(K·w)), using the same tail d read for that sample and the w stored for it.
- R3: The feedback term scales only the tail (K·d); the input is added after the scaling, so (x + d)·K is never formed.
- R4: With USE_VAR_COEF = 1, K is the value on coef_in in the cycle in_valid is high. With USE_VAR_COEF = 0, K is FIXED_COEF (default 3103785, i.e. 0.37 in Q1.23) and coef_in has no effect on out_sample.
- R5: Every sum and product saturates to the range −8388608..8388607 instead of wrapping. The product −1.0 × −1.0 gives 8388607.
- R6: The tail read for a sample is the value stored DEPTH accepted samples earlier. It is 0 while fewer than DEPTH samples have been accepted since reset.
- R7: out_valid is high exactly two clock cycles after each cycle with in_valid high and low otherwise, including for inputs on consecutive cycles.
- R8: out_sample changes only in a cycle where out_valid is high and holds its value otherwise.
- R9: While rst is high, and right after it, out_valid is 0, out_sample is 0 and the whole delay line is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; clears the line and outputs |
| in_valid | input | 1 | Strobe: in_sample (and coef_in) are taken this cycle |
| in_sample | input | 24 | Input sample x, signed Q1.23 |
| coef_in | input | 24 | Run-time coefficient K, signed Q1.23 (used when USE_VAR_COEF = 1) |
| out_valid | output | 1 | High for one cycle, two cycles after each in_valid |
| out_sample | output | 24 | Output sample y, signed Q1.23 |

## Verification
A single impulse followed by silence shows the tail being recalled exactly DEPTH samples later. It also shows that the stored value comes back into the output, which separates w = x + K·d from a line that merely delays x. A stream of changing inputs with a coefficient that changes every sample separates the correct feedback from the (x + d)·K form. The same stream tells apart a coefficient sampled per input from a stale one, and it shows that the fixed variant ignores coef_in. Zero coefficients turn the stage into a pure delay. Back-to-back bursts and full-scale values show the fixed latency and the clamping.

// File: rtl/apf_pkg.sv
package apf_pkg;
  localparam int SW   = 24;
  localparam int FRAC = SW - 1;

  typedef logic signed [SW-1:0] smp_t;
  typedef logic signed [SW:0]   wide_t;

  localparam smp_t SMP_MAX = {1'b0, {(SW-1){1'b1}}};
  localparam smp_t SMP_MIN = {1'b1, {(SW-1){1'b0}}};
  localparam wide_t WIDE_MAX = {2'b00, {(SW-1){1'b1}}};
  localparam wide_t WIDE_MIN = {2'b11, {(SW-1){1'b0}}};

  // clamp a one-bit-wider value into the sample range
  function automatic smp_t clamp_wide(input wide_t v);
    if (v > WIDE_MAX)      return SMP_MAX;
    else if (v < WIDE_MIN) return SMP_MIN;
    else                   return v[SW-1:0];
  endfunction

  // Q1.23 product, floor of the exact value, clamped
  function automatic smp_t q_mul(input smp_t a, input smp_t b);
    logic signed [2*SW-1:0] p;
    p = a * b;
    return clamp_wide($signed(p[2*SW-1:FRAC]));
  endfunction

  function automatic smp_t sat_add(input smp_t a, input smp_t b);
    wide_t s;
    s = $signed({a[SW-1], a}) + $signed({b[SW-1], b});
    return clamp_wide(s);
  endfunction

  function automatic smp_t sat_sub(input smp_t a, input smp_t b);
    wide_t s;
    s = $signed({a[SW-1], a}) - $signed({b[SW-1], b});
    return clamp_wide(s);
  endfunction
endpackage

// File: rtl/apf_coef_src.sv
module apf_coef_src
  import apf_pkg::*;
#(
  parameter bit   USE_VAR = 1'b1,
  parameter smp_t FIXED   = 24'sd3103785
) (
  input  smp_t coef_in,
  output smp_t coef_out
);
  generate
    if (USE_VAR) begin : g_var
      assign coef_out = coef_in;
    end else begin : g_fixed
      logic unused_coef;
      assign unused_coef = ^coef_in;
      assign coef_out = FIXED;
    end
  endgenerate
endmodule

// File: rtl/apf_delay_mem.sv
module apf_delay_mem
  import apf_pkg::*;
#(
  parameter int DEPTH = 205,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output smp_t          rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  smp_t          wr_data
);
  smp_t cells [DEPTH];

  assign rd_data = cells[rd_addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (wr_en) begin
      cells[wr_addr] <= wr_data;
    end
  end

  // R6: a read in the same cycle as a write must see an older slot
  assert_no_collision_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && wr_en) |-> (rd_addr != wr_addr));
endmodule

// File: rtl/apf_mac.sv
module apf_mac
  import apf_pkg::*;
(
  input  smp_t x,
  input  smp_t k,
  input  smp_t tail,
  output smp_t prod_tail,
  output smp_t store_val,
  output smp_t prod_store,
  output smp_t y
);
  // R3: only the tail is scaled; the input joins after the product
  assign prod_tail  = q_mul(k, tail);
  assign store_val  = sat_add(x, prod_tail);      // R1
  assign prod_store = q_mul(k, store_val);
  assign y          = sat_sub(tail, prod_store);  // R2
endmodule

// File: rtl/apf_stage.sv
module apf_stage
  import apf_pkg::*;
#(
  parameter int   DEPTH        = 205,
  parameter bit   USE_VAR_COEF = 1'b1,
  parameter smp_t FIXED_COEF   = 24'sd3103785
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [23:0] in_sample,
  input  logic [23:0] coef_in,
  output logic        out_valid,
  output logic [23:0] out_sample
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] rd_ptr;
  smp_t          coef_now;
  smp_t          tail_rd;

  // stage 1: sample, coefficient, last-read tail and slot
  logic          stg_valid;
  smp_t          stg_x;
  smp_t          stg_k;
  smp_t          stg_tail;
  logic [AW-1:0] stg_addr;

  // stage 2 arithmetic, brought out as named wires
  smp_t prod_tail;
  smp_t store_val;
  smp_t prod_store;
  smp_t y_next;
  smp_t y_q;

  apf_coef_src #(.USE_VAR(USE_VAR_COEF), .FIXED(FIXED_COEF)) u_coef (
    .coef_in (coef_in),
    .coef_out(coef_now)
  );

  apf_delay_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (in_valid),
    .rd_addr(rd_ptr),
    .rd_data(tail_rd),
    .wr_en  (stg_valid),
    .wr_addr(stg_addr),
    .wr_data(store_val)
  );

  apf_mac u_mac (
    .x         (stg_x),
    .k         (stg_k),
    .tail      (stg_tail),
    .prod_tail (prod_tail),
    .store_val (store_val),
    .prod_store(prod_store),
    .y         (y_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr    <= '0;
      stg_valid <= 1'b0;
      stg_x     <= '0;
      stg_k     <= '0;
      stg_tail  <= '0;
      stg_addr  <= '0;
    end else begin
      stg_valid <= in_valid;
      if (in_valid) begin
        stg_x    <= in_sample;
        stg_k    <= coef_now;
        stg_tail <= tail_rd;
        stg_addr <= rd_ptr;
        rd_ptr   <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      y_q       <= '0;
    end else begin
      out_valid <= stg_valid;
      if (stg_valid) y_q <= y_next;
    end
  end

  assign out_sample = y_q;

  // R7: fixed two-cycle path
  assert_stage_fill_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> stg_valid);
  assert_out_follow_R7: assert property (@(posedge clk) disable iff (rst)
    stg_valid |=> out_valid);
  assert_out_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !stg_valid |=> !out_valid);

  // R6: circular slot pointer steps once per accepted sample
  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> rd_ptr == (($past(rd_ptr) == LAST) ? '0 : $past(rd_ptr) + 1'b1));

  // R5: a non-negative tail minus a non-positive product never wraps negative
  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (stg_valid && !stg_tail[23] && (prod_store <= 0)) |=> !out_sample[23]);

  // R8: output holds between results
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !stg_valid |=> $stable(out_sample));
endmodule

// File: tb/test_apf_stage.sv
module test_apf_stage;
  localparam int DT = 7;
  localparam longint KFIX = 3103785;
  localparam longint QMAX = 8388607;
  localparam longint QMIN = -8388608;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [23:0] in_sample = '0;
  logic [23:0] coef_in = '0;
  logic        ov_v, ov_f;
  logic [23:0] os_v, os_f;

  always #10 clk = ~clk;

  apf_stage #(.DEPTH(DT), .USE_VAR_COEF(1'b1)) i_apf_stage (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .coef_in(coef_in), .out_valid(ov_v), .out_sample(os_v));

  apf_stage #(.DEPTH(DT), .USE_VAR_COEF(1'b0)) i_apf_stage_fix (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .coef_in(coef_in), .out_valid(ov_f), .out_sample(os_f));

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;
  int cyc = 0;
  bit sent [4];
  string tag = "R9";

  longint hv [DT];
  longint hf [DT];
  int hp = 0;
  longint qv [$];
  longint qf [$];
  longint last_v = 0, last_f = 0;
  int lcg = 12345;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint clampq(longint v);
    if (v > QMAX) return QMAX;
    if (v < QMIN) return QMIN;
    return v;
  endfunction

  function automatic longint fmul(longint a, longint b);
    longint p, q;
    p = a * b;
    q = p / 8388608;
    if ((p < 0) && (p % 8388608 != 0)) q = q - 1;
    return clampq(q);
  endfunction

  function automatic longint s24(logic [23:0] v);
    return longint'($signed(v));
  endfunction

  task automatic check(string t, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  // one clock: drive, and update the reference lines
  task automatic step(bit v, longint x, longint k);
    longint d, w;
    @(posedge clk);
    #2;
    in_valid  = v;
    in_sample = 24'(x);
    coef_in   = 24'(k);
    sent[cyc & 3] = v;
    if (v) begin
      d = hv[hp];
      w = clampq(x + fmul(k, d));
      hv[hp] = w;
      qv.push_back(clampq(d - fmul(k, w)));
      d = hf[hp];
      w = clampq(x + fmul(KFIX, d));
      hf[hp] = w;
      qf.push_back(clampq(d - fmul(KFIX, w)));
      hp = (hp == DT - 1) ? 0 : hp + 1;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0);
  endtask

  function automatic longint rnd();
    lcg = lcg * 1103515245 + 12345;
    return longint'(lcg[23:0]) - 8388608;
  endfunction

  always @(negedge clk) begin
    if (mon_on) begin
      bit ev;
      ev = sent[(cyc + 2) & 3];
      check("R7 valid timing var", longint'(ov_v), longint'(ev));
      check("R7 valid timing fix", longint'(ov_f), longint'(ev));
      if (ov_v && qv.size() > 0) begin
        check({tag, " out var"}, s24(os_v), qv.pop_front());
        last_v = s24(os_v);
      end else if (!ov_v) check("R8 hold var", s24(os_v), last_v);
      if (ov_f && qf.size() > 0) begin
        check({tag, " out fix"}, s24(os_f), qf.pop_front());
        last_f = s24(os_f);
      end else if (!ov_f) check("R8 hold fix", s24(os_f), last_f);
    end
  end

  task automatic t_reset_r9();
    @(negedge clk);
    check("R9 out_valid in reset", longint'(ov_v), 0);
    check("R9 out_sample in reset", s24(os_v), 0);
    @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    check("R9 out_valid after reset", longint'(ov_f), 0);
    check("R9 out_sample after reset", s24(os_f), 0);
    mon_on = 1'b1;
  endtask

  // single impulse: first outputs see zero tail (R6), then echoes (R1, R2)
  task automatic t_impulse_r1_r2();
    tag = "R1/R2 impulse";
    step(1'b1, 4194304, 3103785);
    idle(2);
    for (int i = 0; i < 2 * DT + 1; i++) step(1'b1, 0, 3103785);
    idle(3);
  endtask

  // changing input and per-sample coefficient (R3, R4)
  task automatic t_sweep_r3_r4();
    tag = "R3/R4 sweep";
    for (int i = 0; i < 40; i++) begin
      step(1'b1, rnd() / 2, rnd());
      if (i % 5 == 4) idle(1);
    end
    idle(3);
  endtask

  // zero coefficient: pure delay of DT samples on the variable instance (R6)
  task automatic t_pure_delay_r6();
    tag = "R6 zero coef";
    for (int i = 0; i < 2 * DT + 2; i++) step(1'b1, (i + 1) * 1000 - 9000, 0);
    idle(3);
  endtask

  // back-to-back bursts and single gaps (R7)
  task automatic t_bursts_r7();
    tag = "R7 burst";
    for (int b = 0; b < 4; b++) begin
      for (int i = 0; i < 3 + b; i++) step(1'b1, rnd() / 4, 2000000 - b * 900000);
      idle(b % 2 + 1);
    end
    idle(3);
  endtask

  // full-scale values, incl. -1.0 * -1.0 (R5)
  task automatic t_saturate_r5();
    tag = "R5 saturation";
    for (int i = 0; i < DT + 2; i++) step(1'b1, QMAX, QMAX);
    for (int i = 0; i < DT + 2; i++) step(1'b1, QMIN, QMIN);
    for (int i = 0; i < DT + 2; i++) step(1'b1, QMAX, QMIN);
    for (int i = 0; i < DT + 2; i++) step(1'b1, QMIN, QMAX);
    idle(3);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < DT; i++) begin hv[i] = 0; hf[i] = 0; end
    for (int i = 0; i < 4; i++) sent[i] = 1'b0;
    repeat (3) @(posedge clk);
    t_reset_r9();
    t_impulse_r1_r2();
    t_sweep_r3_r4();
    t_pure_delay_r6();
    t_bursts_r7();
    t_saturate_r5();
    idle(2);
    mon_on = 1'b0;
    check("R7 all results delivered var", longint'(qv.size()), 0);
    check("R7 all results delivered fix", longint'(qf.size()), 0);
    finish_up();
  end

  initial begin
    #2000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end
endmodule